// File: doc/BRIEF.md
# Pin Sense Interrupt Unit

This block watches the effective input value of a general-purpose I/O port and produces, every clock cycle, a vector of per-pin interrupt flag-set requests. A register block elsewhere ORs this vector into the port's flag register. Flag storage, clearing and bus access live in that register block.

The effective value of a pin is one of two sources:

- For a pin configured as an output, it is the bit the port drives.
- For an input pin, it is the external pad level after a multi-flop synchroniser.

Detection therefore reacts to software writes on output pins as well as to external activity. Each pin carries its own 3-bit sense code. The code picks one of these behaviours:

- any change
- rising change only
- falling change only
- low level
- no flag at all

The flag-set vector is registered. Edge requests last one cycle. A low-level request repeats every cycle the pin stays low, so a flag that software clears is set again while the level persists. After reset the unit waits for the synchroniser to fill and for the previous-value register to load once. Only then does it start reporting, so the reset values never produce a false edge.

Top module: `pin_sense_irq`

## Requirements
- R1: While `rst` is high, and for `SYNC_STAGES+1` cycles after it falls, `flag_set_o` is all zero whatever the pads do. The first reported comparison uses two valid effective values, so a pad held high through reset reports no edge.
- R2: Sense codes 0 (off), 4 (input buffer off), 6 and 7 never set the corresponding bit of `flag_set_o`.
- R3: Sense code 1 sets the pin's bit for exactly one cycle whenever its effective value changes in either direction.
- R4: Sense code 2 sets the pin's bit for one cycle only when the effective value goes from 0 to 1.
- R5: Sense code 3 sets the pin's bit for one cycle only when the effective value goes from 1 to 0.
- R6: Sense code 5 sets the pin's bit on every cycle in which the effective value is 0, continuously, and clears it once the value is 1.
- R7: For a pin with `dir_i` bit = 1, the effective value is its `out_i` bit. A change of `out_i` before a clock edge shows up in `flag_set_o` right after that edge.
- R8: For a pin with `dir_i` bit = 0, the effective value is its pad after `SYNC_STAGES` flops. A pad change before edge A shows up in `flag_set_o` after edge `SYNC_STAGES+1` counting A as the first.
- R9: Pins that trigger in the same cycle all have their bits set in the same `flag_set_o` word.
- R10: An `out_i` change on an input pin, and a pad change on an output pin, set no flag.
- R11: The sense code of pin i is `sense_i[3*i+2:3*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | NPINS | Raw asynchronous pad levels |
| dir_i | input | NPINS | Pin direction, 1 = output |
| out_i | input | NPINS | Driven output bits |
| sense_i | input | 3*NPINS | Per-pin sense codes, pin i at bits 3i+2..3i |
| flag_set_o | output | NPINS | Registered per-pin flag-set requests |

## Verification
The bench builds the block with its defaults: eight pins and a two-flop synchroniser. With these values the three-edge pad latency and the three-cycle warm-up after reset can be counted exactly. All eight sense codes can also be placed side by side in one port word, so the code decode, several pins firing together, and both sources of the effective value are all exercised in a single configuration.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;
  localparam int SENSE_W = 3;

  typedef enum logic [SENSE_W-1:0] {
    SNS_OFF   = 3'd0,
    SNS_ANY   = 3'd1,
    SNS_RISE  = 3'd2,
    SNS_FALL  = 3'd3,
    SNS_NOBUF = 3'd4,
    SNS_LOW   = 3'd5,
    SNS_RSV6  = 3'd6,
    SNS_RSV7  = 3'd7
  } sense_e;

  // Decide whether one pin requests a flag, given its previous and current effective value.
  function automatic logic sense_hit(input logic [SENSE_W-1:0] code,
                                     input logic prev, input logic cur);
    logic hit;
    case (sense_e'(code))
      SNS_ANY:  hit = prev ^ cur;
      SNS_RISE: hit = ~prev & cur;
      SNS_FALL: hit = prev & ~cur;
      SNS_LOW:  hit = ~cur;
      default:  hit = 1'b0;  // off, input-buffer-off, reserved
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/pin_sense_sync.sv
module pin_sense_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pin_sense_warmup.sv
module pin_sense_warmup #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  output logic armed_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign armed_o = (cnt == LIMIT);
endmodule

// File: rtl/pin_sense_cell.sv
module pin_sense_cell
  import pin_sense_pkg::*;
(
  input  logic [SENSE_W-1:0] code_i,
  input  logic               prev_i,
  input  logic               cur_i,
  output logic               hit_o
);
  always_comb hit_o = sense_hit(code_i, prev_i, cur_i);
endmodule

// File: rtl/pin_sense_irq.sv
module pin_sense_irq
  import pin_sense_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPINS-1:0]         pad_i,
  input  logic [NPINS-1:0]         dir_i,
  input  logic [NPINS-1:0]         out_i,
  input  logic [NPINS*SENSE_W-1:0] sense_i,
  output logic [NPINS-1:0]         flag_set_o
);
  localparam int WARM = SYNC_STAGES + 1;

  logic [NPINS-1:0] pad_s;
  logic [NPINS-1:0] eff;
  logic [NPINS-1:0] eff_q;
  logic [NPINS-1:0] hit;
  logic             armed;

  pin_sense_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pad_i), .q_o(pad_s)
  );

  pin_sense_warmup #(.CYCLES(WARM)) u_warm (
    .clk(clk), .rst(rst), .armed_o(armed)
  );

  // Output pins read back their driven bit; input pins see the synchronised pad.
  assign eff = (dir_i & out_i) | (~dir_i & pad_s);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_sense_cell u_cell (
      .code_i(sense_i[i*SENSE_W +: SENSE_W]),
      .prev_i(eff_q[i]),
      .cur_i (eff[i]),
      .hit_o (hit[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q      <= '0;
      flag_set_o <= '0;
    end else begin
      eff_q      <= eff;
      flag_set_o <= armed ? hit : '0;
    end
  end
endmodule

// File: rtl/pin_sense_irq_chk.sv
module pin_sense_irq_chk #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NPINS*3-1:0] sense_i,
  input logic [NPINS-1:0]   flag_set_o,
  input logic [NPINS-1:0]   eff,
  input logic [NPINS-1:0]   eff_q,
  input logic               armed
);
  // R1: nothing is reported before the unit is armed
  p_quiet_warmup_r1: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (flag_set_o == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [2:0] code;
    assign code = sense_i[3*i +: 3];

    p_silent_codes_r2: assert property (@(posedge clk) disable iff (rst)
      (code == 3'd0 || code == 3'd4 || code == 3'd6 || code == 3'd7) |=> !flag_set_o[i]);

    p_any_change_r3: assert property (@(posedge clk) disable iff (rst)
      (armed && code == 3'd1 && (eff_q[i] != eff[i])) |=> flag_set_o[i]);

    p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
      (code == 3'd2 && !(!eff_q[i] && eff[i])) |=> !flag_set_o[i]);

    p_fall_only_r5: assert property (@(posedge clk) disable iff (rst)
      (code == 3'd3 && !(eff_q[i] && !eff[i])) |=> !flag_set_o[i]);

    p_low_level_r6: assert property (@(posedge clk) disable iff (rst)
      (armed && code == 3'd5 && !eff[i]) |=> flag_set_o[i]);
  end
endmodule

bind pin_sense_irq pin_sense_irq_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .sense_i(sense_i), .flag_set_o(flag_set_o),
  .eff(eff), .eff_q(eff_q), .armed(armed)
);

// File: tb/pin_sense_irq_test.sv
`timescale 1ns/1ps
module pin_sense_irq_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pad = '0;
  logic [N-1:0] dir = '0;
  logic [N-1:0] outv = '0;
  logic [N*3-1:0] sense = '0;
  logic [N-1:0] flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pin_sense_irq #(.NPINS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pad_i(pad), .dir_i(dir), .out_i(outv),
    .sense_i(sense), .flag_set_o(flags)
  );

  // Expected flag word from the requirements (codes per R2..R6, field per R11)
  function automatic logic [N-1:0] expect_flags(logic [N*3-1:0] s, logic [N-1:0] p, logic [N-1:0] c);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      case (s[3*i +: 3])
        3'd1:    e[i] = p[i] != c[i];
        3'd2:    e[i] = !p[i] && c[i];
        3'd3:    e[i] = p[i] && !c[i];
        3'd5:    e[i] = !c[i];
        default: e[i] = 1'b0;
      endcase
    end
    return e;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [N-1:0] exp);
    checks++;
    if (flags !== exp) begin
      errors++;
      $display("FAIL %s: flag_set_o=%02h expected=%02h", tag, flags, exp);
    end
  endtask

  task automatic settle(logic [N-1:0] d, logic [N-1:0] o, logic [N-1:0] p);
    sense = '0; dir = d; outv = o; pad = p;
    tick(4);
  endtask

  task automatic t_reset();
    rst = 1'b1; pad = '1; dir = '0; sense = {N{3'd1}};
    tick(3);
    check("R1 in reset", '0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      check("R1 warm-up, pad high through reset", '0);
    end
  endtask

  task automatic t_out_edges();
    logic [N-1:0] seq [4] = '{8'hFF, 8'h00, 8'hA5, 8'h5A};
    logic [N-1:0] prev;
    settle('1, '0, '0);
    // pin0 any, 1 rise, 2 fall, 3 off, 4 no-buffer, 5 low, 6/7 reserved
    sense = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    sense = {3'd7, 3'd6, 3'd5, 3'd4, 3'd0, 3'd3, 3'd2, 3'd1};
    tick(1);
    check("R6 R11 level on output pin", expect_flags(sense, 8'h00, 8'h00));
    prev = 8'h00;
    for (int k = 0; k < 4; k++) begin
      outv = seq[k];
      tick(1);
      check("R2 R3 R4 R5 R7 R9 output write edge", expect_flags(sense, prev, seq[k]));
      tick(1);
      check("R3 R4 R5 edge is one cycle", expect_flags(sense, seq[k], seq[k]));
      prev = seq[k];
    end
  endtask

  task automatic t_pad_latency();
    settle('0, '0, '0);
    sense = {N{3'd1}};
    tick(1);
    pad = 8'h3C;
    tick(1);
    check("R8 pad not yet visible (1)", '0);
    tick(1);
    check("R8 pad not yet visible (2)", '0);
    tick(1);
    check("R8 R9 pad edge after sync", 8'h3C);
    tick(1);
    check("R3 pad edge one cycle", '0);
    pad = 8'h00;
    tick(3);
    check("R8 R3 pad falling after sync", 8'h3C);
  endtask

  task automatic t_ignore();
    settle('0, '0, '0);
    sense = {N{3'd1}};
    tick(1);
    outv = '1;
    tick(1);
    check("R10 out change on input pin", '0);
    tick(1);
    check("R10 out change on input pin, next", '0);
    settle('1, '0, '0);
    sense = {N{3'd1}};
    tick(1);
    pad = '1;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      check("R10 pad change on output pin", '0);
    end
  endtask

  task automatic t_level();
    settle('1, '1, '0);
    sense = {3'd0, {7{3'd5}}};
    tick(1);
    check("R6 high level no flag", '0);
    outv = '0;
    for (int k = 0; k < 3; k++) begin
      tick(1);
      check("R6 R2 low level every cycle", 8'h7F);
    end
    outv = '1;
    tick(1);
    check("R6 level released", '0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(1);
    t_reset();
    t_out_edges();
    t_pad_latency();
    t_ignore();
    t_level();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule